// File: doc/BRIEF.md
# NAND Page Register Column Pointer

This block sits inside a NAND flash device model, next to a 528-byte page buffer. It watches the command, address and data strobes of the multiplexed byte bus and produces the 10-bit column index that selects the byte of the page buffer being read or written. Three pointer commands select an area: the first half (columns 0 to 255), the second half (256 to 511), or the 16-byte spare area (512 to 527). The first address byte after a command then fixes the starting column inside that area.

Each read strobe and each data-input strobe advances the column by one. At the last reachable column the pointer stops and raises an end-of-page flag instead of wrapping. The second-half setting is consumed by one address load, after which the pointer falls back to the first half. A spare-disable input keeps the spare columns out of reach, both for selection and for stepping.

All strobes are single-cycle pulses, synchronous to `clk`, and the column register updates on the same edge that samples a strobe. If a command strobe and an address strobe arrive together, the command wins. Either of those takes precedence over a step.

Top module: `nand_colptr`

## Requirements
- R1: After reset, `col_idx` is 0 and `page_end` is 0.
- R2: Command code 0x00 followed by address byte B sets `col_idx` to B on the edge that samples the address strobe.
- R3: Command code 0x01 followed by address byte B sets `col_idx` to 256 + B.
- R4: Once an address byte has been loaded in second-half mode, the mode reverts to first half. A later address load that is not preceded by a fresh 0x01 lands at column B.
- R5: With `spare_dis` low, command code 0x50 followed by address byte B sets `col_idx` to 512 + B[3:0].
- R6: With `spare_dis` high, command code 0x50 is ignored. The area already selected stays in force, so the next address load follows that area.
- R7: Only the first address strobe after a command loads the column. Second and later address strobes leave `col_idx` unchanged.
- R8: Each `rd_stb` pulse increments `col_idx` by one on the sampling edge.
- R9: Each `din_stb` pulse increments `col_idx` by one on the sampling edge.
- R10: With `spare_dis` low, a step at column 527 keeps `col_idx` at 527 and sets `page_end`. While `page_end` is set, steps do not move the column. The next address load clears `page_end`.
- R11: With `spare_dis` high, a step at column 511 keeps `col_idx` at 511 and sets `page_end`.
- R12: A command code other than 0x00, 0x01 or 0x50 leaves `col_idx` and the selected area unchanged. Like any command, it restarts the address-cycle count.
- R13: If spare mode is selected and `spare_dis` is high when the address byte arrives, the load lands at first-half column B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | Command byte strobe (one cycle) |
| addr_stb | input | 1 | Address byte strobe (one cycle) |
| rd_stb | input | 1 | Read data strobe, advances column |
| din_stb | input | 1 | Data-input strobe, advances column |
| io_byte | input | 8 | Command code or address byte |
| spare_dis | input | 1 | High keeps the spare columns out of reach |
| col_idx | output | 10 | Current page register column |
| page_end | output | 1 | Set when a step hit the last reachable column |

## Verification
A wrong area register shows up as an offset of 256 or 512 in `col_idx` on the very edge of the next address load. The error stays invisible until that load, which is why each mode change is followed by a load and an immediate comparison. A wrong address-cycle count shows as a jump in the column on the second or third address byte. A wrong bound or a missing stop shows one step after column 511 or 527, as a wrapped index or a missing `page_end`.

// File: rtl/nand_colptr_pkg.sv
package nand_colptr_pkg;

    localparam int HALF_BYTES  = 256;
    localparam int SPARE_BYTES = 16;
    localparam int ADDR_CYCLES = 3;
    localparam int MAIN_BYTES  = 2 * HALF_BYTES;
    localparam int PAGE_BYTES  = MAIN_BYTES + SPARE_BYTES;
    localparam int COL_W       = $clog2(PAGE_BYTES);
    localparam int SPARE_W     = $clog2(SPARE_BYTES);
    localparam int ACNT_W      = $clog2(ADDR_CYCLES + 1);

    typedef logic [COL_W-1:0] col_t;

    typedef enum logic [1:0] {
        AREA_LOW   = 2'd0,
        AREA_HIGH  = 2'd1,
        AREA_SPARE = 2'd2
    } area_e;

    localparam logic [7:0] OP_LOW   = 8'h00;
    localparam logic [7:0] OP_HIGH  = 8'h01;
    localparam logic [7:0] OP_SPARE = 8'h50;

    function automatic col_t start_col(area_e a, logic [7:0] b, logic sdis);
        col_t c;
        case (a)
            AREA_HIGH:  c = col_t'(HALF_BYTES) + col_t'(b);
            AREA_SPARE: c = sdis ? col_t'(b)
                                 : col_t'(MAIN_BYTES) + col_t'(b[SPARE_W-1:0]);
            default:    c = col_t'(b);
        endcase
        return c;
    endfunction

    function automatic col_t last_col(logic sdis);
        return sdis ? col_t'(MAIN_BYTES - 1) : col_t'(PAGE_BYTES - 1);
    endfunction

endpackage

// File: rtl/colptr_area.sv
module colptr_area
    import nand_colptr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_stb,
    input  logic [7:0] cmd_code,
    input  logic       spare_dis,
    input  logic       load,
    output area_e      area
);
    area_e area_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            area_q <= AREA_LOW;
        end else if (cmd_stb) begin
            case (cmd_code)
                OP_LOW:   area_q <= AREA_LOW;
                OP_HIGH:  area_q <= AREA_HIGH;
                OP_SPARE: if (!spare_dis) area_q <= AREA_SPARE;
                default:  area_q <= area_q;
            endcase
        end else if (load && area_q == AREA_HIGH) begin
            area_q <= AREA_LOW;
        end
    end

    assign area = area_q;

    // R4: second-half mode is consumed by one load
    a_r4_high_reverts: assert property (@(posedge clk) disable iff (rst)
        (load && !cmd_stb && area_q == AREA_HIGH) |=> area_q == AREA_LOW);

    // R6: spare select refused while spare is disabled
    a_r6_spare_refused: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && cmd_code == OP_SPARE && spare_dis) |=> area_q == $past(area_q));

    // R12: undefined codes leave the area alone
    a_r12_undef_keeps: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && cmd_code != OP_LOW && cmd_code != OP_HIGH && cmd_code != OP_SPARE)
        |=> area_q == $past(area_q));
endmodule

// File: rtl/colptr_acycle.sv
module colptr_acycle
    import nand_colptr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_stb,
    input  logic addr_stb,
    output logic load
);
    logic [ACNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || cmd_stb) begin
            cnt_q <= '0;
        end else if (addr_stb && cnt_q != ACNT_W'(ADDR_CYCLES)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign load = addr_stb && !cmd_stb && (cnt_q == '0);

    // R7: a load is never followed directly by a second load
    a_r7_single_load: assert property (@(posedge clk) disable iff (rst)
        load |=> !load);
endmodule

// File: rtl/colptr_counter.sv
module colptr_counter
    import nand_colptr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  col_t load_col,
    input  logic step,
    input  col_t limit,
    output col_t col,
    output logic eop
);
    col_t col_q;
    logic eop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            eop_q <= 1'b0;
        end else if (load) begin
            col_q <= load_col;
            eop_q <= 1'b0;
        end else if (step && !eop_q) begin
            if (col_q >= limit) begin
                eop_q <= 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    assign col = col_q;
    assign eop = eop_q;

    // R8 / R9: a step below the bound advances by exactly one
    a_r8_step_one: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !eop_q && col_q < limit) |=> col_q == $past(col_q) + 1'b1);

    // R10: the end flag freezes the column until a load
    a_r10_eop_hold: assert property (@(posedge clk) disable iff (rst)
        (eop_q && !load) |=> $stable(col_q) && eop_q);

    // R10: column never leaves the page
    a_r10_in_page: assert property (@(posedge clk) disable iff (rst)
        col_q <= col_t'(PAGE_BYTES - 1));
endmodule

// File: rtl/nand_colptr.sv
module nand_colptr
    import nand_colptr_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_stb,
    input  logic                       addr_stb,
    input  logic                       rd_stb,
    input  logic                       din_stb,
    input  logic [7:0]                 io_byte,
    input  logic                       spare_dis,
    output logic [COL_W-1:0]           col_idx,
    output logic                       page_end
);
    area_e area;
    logic  load;
    logic  step;
    col_t  col;

    colptr_area u_area (
        .clk      (clk),
        .rst      (rst),
        .cmd_stb  (cmd_stb),
        .cmd_code (io_byte),
        .spare_dis(spare_dis),
        .load     (load),
        .area     (area)
    );

    colptr_acycle u_acycle (
        .clk     (clk),
        .rst     (rst),
        .cmd_stb (cmd_stb),
        .addr_stb(addr_stb),
        .load    (load)
    );

    assign step = (rd_stb || din_stb) && !cmd_stb && !addr_stb;

    colptr_counter u_counter (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .load_col(start_col(area, io_byte, spare_dis)),
        .step    (step),
        .limit   (last_col(spare_dis)),
        .col     (col),
        .eop     (page_end)
    );

    assign col_idx = col;

    // R11: with spare disabled a step never reaches the spare columns
    a_r11_no_spare_step: assert property (@(posedge clk) disable iff (rst)
        (spare_dis && step && !load && col <= col_t'(MAIN_BYTES - 1))
        |=> col_idx <= col_t'(MAIN_BYTES - 1));
endmodule

// File: tb/nand_colptr_bench.sv
module nand_colptr_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_stb, addr_stb, rd_stb, din_stb, spare_dis;
    logic [7:0] io_byte;
    logic [9:0] col_idx;
    logic       page_end;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_colptr u_nand_colptr (
        .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .addr_stb(addr_stb),
        .rd_stb(rd_stb), .din_stb(din_stb), .io_byte(io_byte),
        .spare_dis(spare_dis), .col_idx(col_idx), .page_end(page_end)
    );

    task automatic chk(string req, int got_col, int exp_col, bit got_e, bit exp_e);
        checks++;
        if (got_col != exp_col || got_e != exp_e) begin
            errors++;
            $display("FAIL %s col=%0d end=%0d expected col=%0d end=%0d",
                     req, got_col, got_e, exp_col, exp_e);
        end
    endtask

    // each pulse: drive at negedge, hold one cycle, release at next negedge
    task automatic cmd(input logic [7:0] c);
        io_byte = c; cmd_stb = 1'b1;
        @(negedge clk); cmd_stb = 1'b0;
    endtask
    task automatic addr(input logic [7:0] b);
        io_byte = b; addr_stb = 1'b1;
        @(negedge clk); addr_stb = 1'b0;
    endtask
    task automatic rd();
        rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
    endtask
    task automatic din();
        din_stb = 1'b1; @(negedge clk); din_stb = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", col_idx, 0, page_end, 0);
    endtask

    task automatic t_low_and_steps();
        cmd(8'h00); addr(8'h34);
        chk("R2", col_idx, 52, page_end, 0);
        addr(8'h77); addr(8'h11);
        chk("R7", col_idx, 52, page_end, 0);
        rd(); rd(); rd();
        chk("R8", col_idx, 55, page_end, 0);
        din(); din();
        chk("R9", col_idx, 57, page_end, 0);
    endtask

    task automatic t_high_and_revert();
        cmd(8'h01);
        cmd(8'hAA);
        chk("R12", col_idx, 57, page_end, 0);
        addr(8'h05);
        chk("R3", col_idx, 261, page_end, 0);
        cmd(8'h80); addr(8'h05);
        chk("R4", col_idx, 5, page_end, 0);
    endtask

    task automatic t_spare_and_end();
        spare_dis = 1'b0;
        cmd(8'h50); addr(8'hF3);
        chk("R5", col_idx, 515, page_end, 0);
        cmd(8'h50); addr(8'h0E);
        rd();
        chk("R10", col_idx, 527, page_end, 0);
        rd();
        chk("R10", col_idx, 527, page_end, 1);
        din();
        chk("R10", col_idx, 527, page_end, 1);
        cmd(8'h00); addr(8'h00);
        chk("R10", col_idx, 0, page_end, 0);
    endtask

    task automatic t_spare_disabled();
        cmd(8'h00);
        spare_dis = 1'b1;
        cmd(8'h50); addr(8'h22);
        chk("R6", col_idx, 34, page_end, 0);
        cmd(8'h01); addr(8'hFF);
        chk("R11", col_idx, 511, page_end, 0);
        rd();
        chk("R11", col_idx, 511, page_end, 1);
        spare_dis = 1'b0;
        cmd(8'h50);
        spare_dis = 1'b1;
        addr(8'h03);
        chk("R13", col_idx, 3, page_end, 0);
        spare_dis = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_stb = 1'b0; addr_stb = 1'b0; rd_stb = 1'b0;
        din_stb = 1'b0; spare_dis = 1'b0; io_byte = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_low_and_steps();
        t_high_and_revert();
        t_spare_and_end();
        t_spare_disabled();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule